// File: doc/BRIEF.md
# Serial and Modem Diagnostic Loop Switch

This block sits between a UART's serializer, deserializer and modem-control logic on one side and the device pins on the other. A single control bit selects one of two modes. In normal mode the serial stream and the four modem control outputs pass straight through to the pins. The four external modem status inputs are synchronized into the clock domain and tracked.

In diagnostic loop mode the pins are cut off from the core. The transmit stream is returned to the receiver. The four status inputs are driven from the control bits through a fixed crossover, so software can test the whole serial and modem path without any outside wiring.

The block also holds the modem status byte. The high nibble carries the present status levels and the low nibble carries sticky change flags, which a status-read strobe clears. It raises a modem interrupt request when any flag is set and the matching enable is on. The flags and the interrupt work in both modes.

The mode is held by a two-state machine. `MODE_NORMAL` moves to `MODE_LOOP` through transition `GO_LOOP` when the loop bit is 1. `MODE_LOOP` returns to `MODE_NORMAL` through transition `GO_NORMAL` when the loop bit is 0. Both transitions happen at a clock edge.

Top module: `uart_lpbk_switch`

## Requirements
- R1: After reset the block is in normal mode, `msr_o` is 0x00 and `modem_irq_o` is 0. Bit 4 of `mcr_i` selects the mode (1 = loop), and the selection takes effect at the next rising clock edge.
- R2: In normal mode, `pin_txd_o` follows `core_txd_i` and `core_rxd_o` follows `pin_rxd_i`. The pins `pin_dtr_o`, `pin_rts_o`, `pin_op1_o` and `pin_op2_o` follow `mcr_i` bits 0, 1, 2 and 3 respectively.
- R3: In loop mode, `core_rxd_o` follows `core_txd_i`, `pin_txd_o` is held at 1, and `pin_rxd_i` has no effect.
- R4: In loop mode, `pin_dtr_o`, `pin_rts_o`, `pin_op1_o` and `pin_op2_o` are all 0 whatever `mcr_i` holds.
- R5: In loop mode, the status inputs are driven as follows: CTS from `mcr_i[1]`, DSR from `mcr_i[0]`, RI from `mcr_i[2]` and CD from `mcr_i[3]`. The external status pins have no effect.
- R6: `msr_o[7:4]` holds the status levels in the order CD (bit 7), RI (bit 6), DSR (bit 5), CTS (bit 4). In normal mode an external pin change appears there on the third rising edge after it is applied (two synchronizer stages plus the status register). In loop mode an `mcr_i` change appears on the first rising edge.
- R7: `msr_o` bit 3 (CD), bit 1 (DSR) and bit 0 (CTS) are change flags. Each is set by any change of its status level.
- R8: `msr_o` bit 2 is set only when RI falls from 1 to 0. A rising RI leaves it unchanged.
- R9: A rising edge with `msr_rd_i` high clears all flags. If a status change arrives on that same edge, the flag for that change is set after the edge.
- R10: `modem_irq_o` is 1 exactly when `msr_irq_en_i` is 1 and at least one flag in `msr_o[3:0]` is set.
- R11: Switching modes changes the status source. Any level difference that results sets the flags in the same way as a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_i | input | 5 | Modem control bits: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loop select |
| msr_rd_i | input | 1 | One-cycle strobe: the status byte is being read |
| msr_irq_en_i | input | 1 | Modem status interrupt enable |
| core_txd_i | input | 1 | Serial data from the transmitter |
| core_rxd_o | output | 1 | Serial data to the receiver |
| pin_txd_o | output | 1 | Transmit pin |
| pin_rxd_i | input | 1 | Receive pin |
| pin_cts_i | input | 1 | External CTS, asserted high |
| pin_dsr_i | input | 1 | External DSR, asserted high |
| pin_ri_i | input | 1 | External RI, asserted high |
| pin_cd_i | input | 1 | External CD, asserted high |
| pin_dtr_o | output | 1 | DTR pin, asserted high |
| pin_rts_o | output | 1 | RTS pin, asserted high |
| pin_op1_o | output | 1 | OP1 pin, asserted high |
| pin_op2_o | output | 1 | OP2 pin, asserted high |
| msr_o | output | 8 | Status levels [7:4] and change flags [3:0] |
| modem_irq_o | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with its default of two synchronizer stages and times every external status check from that value. This means it checks that the status level is still missing after two edges and present after the third. With that latency pinned, the bench can line up a status-read strobe with a change arriving on the same edge, so the rule that a new change wins over the clear is exercised directly. It also walks the loop crossover one control bit at a time. This separates each mapping and shows the RI trailing-edge rule from both sides.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
    typedef enum logic [0:0] {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } lpbk_mode_e;

    localparam int MODEM_W = 4;
    localparam int CTRL_W  = 5;

    // status vector order, also the nibble order of the status byte
    localparam int ST_CTS = 0;
    localparam int ST_DSR = 1;
    localparam int ST_RI  = 2;
    localparam int ST_CD  = 3;

    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OP1  = 2;
    localparam int CB_OP2  = 3;
    localparam int CB_LOOP = 4;
endpackage

// File: rtl/lpbk_sync.sv
module lpbk_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[g]};
            end
        end
        assign q_o[g] = chain_q[LAST];
    end
endmodule

// File: rtl/lpbk_mode_fsm.sv
module lpbk_mode_fsm
    import lpbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_req_i,
    output logic loop_o
);
    lpbk_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (loop_req_i)  state_d = MODE_LOOP;    // GO_LOOP
            MODE_LOOP:   if (!loop_req_i) state_d = MODE_NORMAL;  // GO_NORMAL
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        loop_o = (state_q == MODE_LOOP);
    end
endmodule

// File: rtl/lpbk_route.sv
module lpbk_route
    import lpbk_pkg::*;
(
    input  logic               loop_i,
    input  logic [CTRL_W-2:0]  ctrl_i,
    input  logic               core_txd_i,
    input  logic               pin_rxd_i,
    input  logic [MODEM_W-1:0] ext_stat_i,
    output logic               pin_txd_o,
    output logic               core_rxd_o,
    output logic [CTRL_W-2:0]  pin_ctrl_o,
    output logic [MODEM_W-1:0] stat_o
);
    logic [MODEM_W-1:0] looped;

    always_comb begin
        looped         = '0;
        looped[ST_CTS] = ctrl_i[CB_RTS];
        looped[ST_DSR] = ctrl_i[CB_DTR];
        looped[ST_RI]  = ctrl_i[CB_OP1];
        looped[ST_CD]  = ctrl_i[CB_OP2];
    end

    always_comb begin
        if (loop_i) begin
            pin_txd_o  = 1'b1;
            core_rxd_o = core_txd_i;
            pin_ctrl_o = '0;
            stat_o     = looped;
        end else begin
            pin_txd_o  = core_txd_i;
            core_rxd_o = pin_rxd_i;
            pin_ctrl_o = ctrl_i;
            stat_o     = ext_stat_i;
        end
    end
endmodule

// File: rtl/lpbk_msr_track.sv
module lpbk_msr_track
    import lpbk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODEM_W-1:0] stat_i,
    input  logic               rd_i,
    output logic [MODEM_W-1:0] level_o,
    output logic [MODEM_W-1:0] flag_o
);
    logic [MODEM_W-1:0] level_q, flag_q, delta, flag_d;

    always_comb begin
        delta        = stat_i ^ level_q;
        delta[ST_RI] = level_q[ST_RI] & ~stat_i[ST_RI];
        flag_d       = (rd_i ? '0 : flag_q) | delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            flag_q  <= '0;
        end else begin
            level_q <= stat_i;
            flag_q  <= flag_d;
        end
    end

    assign level_o = level_q;
    assign flag_o  = flag_q;
endmodule

// File: rtl/uart_lpbk_switch.sv
module uart_lpbk_switch
    import lpbk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] mcr_i,
    input  logic              msr_rd_i,
    input  logic              msr_irq_en_i,
    input  logic              core_txd_i,
    output logic              core_rxd_o,
    output logic              pin_txd_o,
    input  logic              pin_rxd_i,
    input  logic              pin_cts_i,
    input  logic              pin_dsr_i,
    input  logic              pin_ri_i,
    input  logic              pin_cd_i,
    output logic              pin_dtr_o,
    output logic              pin_rts_o,
    output logic              pin_op1_o,
    output logic              pin_op2_o,
    output logic [7:0]        msr_o,
    output logic              modem_irq_o
);
    logic               loop;
    logic [MODEM_W-1:0] ext_raw, ext_sync, stat_sel, level, flag;
    logic [CTRL_W-2:0]  pin_ctrl;

    always_comb begin
        ext_raw         = '0;
        ext_raw[ST_CTS] = pin_cts_i;
        ext_raw[ST_DSR] = pin_dsr_i;
        ext_raw[ST_RI]  = pin_ri_i;
        ext_raw[ST_CD]  = pin_cd_i;
    end

    lpbk_sync #(.WIDTH(MODEM_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_raw),
        .q_o   (ext_sync)
    );

    lpbk_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_req_i (mcr_i[CB_LOOP]),
        .loop_o     (loop)
    );

    lpbk_route u_route (
        .loop_i     (loop),
        .ctrl_i     (mcr_i[CTRL_W-2:0]),
        .core_txd_i (core_txd_i),
        .pin_rxd_i  (pin_rxd_i),
        .ext_stat_i (ext_sync),
        .pin_txd_o  (pin_txd_o),
        .core_rxd_o (core_rxd_o),
        .pin_ctrl_o (pin_ctrl),
        .stat_o     (stat_sel)
    );

    lpbk_msr_track u_msr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_i  (stat_sel),
        .rd_i    (msr_rd_i),
        .level_o (level),
        .flag_o  (flag)
    );

    assign pin_dtr_o   = pin_ctrl[CB_DTR];
    assign pin_rts_o   = pin_ctrl[CB_RTS];
    assign pin_op1_o   = pin_ctrl[CB_OP1];
    assign pin_op2_o   = pin_ctrl[CB_OP2];
    assign msr_o       = {level, flag};
    assign modem_irq_o = msr_irq_en_i & (|flag);
endmodule

// File: rtl/lpbk_switch_chk.sv
module lpbk_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] mcr_i,
    input logic       msr_rd_i,
    input logic       msr_irq_en_i,
    input logic       core_txd_i,
    input logic       core_rxd_o,
    input logic       pin_txd_o,
    input logic       pin_dtr_o,
    input logic       pin_rts_o,
    input logic       pin_op1_o,
    input logic       pin_op2_o,
    input logic [7:0] msr_o,
    input logic       modem_irq_o
);
    // R3
    loop_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mcr_i[4])) |-> (pin_txd_o && (core_rxd_o == core_txd_i)));

    // R4
    loop_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mcr_i[4])) |->
            !(pin_dtr_o || pin_rts_o || pin_op1_o || pin_op2_o));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_irq_en_i |-> !modem_irq_o);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msr_rd_i |=> ((msr_o[3:0] == 4'h0) || (msr_o[7:4] != $past(msr_o[7:4]))));

    // R8
    ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msr_o[6]) && !$past(msr_o[2])) |-> !msr_o[2]);

    // R7
    cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msr_o[4]) |-> msr_o[0]);
endmodule

bind uart_lpbk_switch lpbk_switch_chk u_chk (.*);

// File: tb/uart_lpbk_switch_bench.sv
module uart_lpbk_switch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mcr_i = '0;
    logic       msr_rd_i = 1'b0;
    logic       msr_irq_en_i = 1'b0;
    logic       core_txd_i = 1'b1;
    logic       core_rxd_o;
    logic       pin_txd_o;
    logic       pin_rxd_i = 1'b1;
    logic       pin_cts_i = 1'b0;
    logic       pin_dsr_i = 1'b0;
    logic       pin_ri_i = 1'b0;
    logic       pin_cd_i = 1'b0;
    logic       pin_dtr_o, pin_rts_o, pin_op1_o, pin_op2_o;
    logic [7:0] msr_o;
    logic       modem_irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_lpbk_switch #(.SYNC_STAGES(2)) u_uart_lpbk_switch (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_msr();
        msr_rd_i = 1'b1;
        step(1);
        msr_rd_i = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_pins();
        return {4'h0, pin_op2_o, pin_op1_o, pin_rts_o, pin_dtr_o};
    endfunction

    task automatic t_reset();
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 reset msr", msr_o, 8'h00);
        check("R1 reset irq", {7'h0, modem_irq_o}, 8'h00);
        core_txd_i = 1'b0;
        #1;
        check("R1 reset normal tx", {7'h0, pin_txd_o}, 8'h00);
    endtask

    task automatic t_normal_path();
        core_txd_i = 1'b1; pin_rxd_i = 1'b0;
        #1;
        check("R2 tx pass", {7'h0, pin_txd_o}, 8'h01);
        check("R2 rx pass", {7'h0, core_rxd_o}, 8'h00);
        mcr_i = 5'h0F;
        #1;
        check("R2 ctrl pins", ctrl_pins(), 8'h0F);
        mcr_i = 5'h02;
        #1;
        check("R2 rts only", ctrl_pins(), 8'h02);
        mcr_i = 5'h00;
        step(1);
    endtask

    task automatic t_normal_status();
        pin_cts_i = 1'b1;
        step(2);
        check("R6 sync latency", msr_o, 8'h00);
        step(1);
        check("R7 cts change", msr_o, 8'h11);
        read_msr();
        check("R9 read clears", msr_o, 8'h10);
        pin_dsr_i = 1'b1; pin_cd_i = 1'b1;
        step(3);
        check("R7 dsr cd change", msr_o, 8'hBA);
        read_msr();
        pin_ri_i = 1'b1;
        step(3);
        check("R8 ri rise no flag", msr_o, 8'hF0);
        pin_ri_i = 1'b0;
        step(3);
        check("R8 ri fall flag", msr_o, 8'hB4);
        read_msr();
        pin_cts_i = 1'b0; pin_dsr_i = 1'b0; pin_cd_i = 1'b0;
        step(3);
        check("R7 all drop", msr_o, 8'h0B);
        msr_irq_en_i = 1'b0;
        #1;
        check("R10 irq masked", {7'h0, modem_irq_o}, 8'h00);
        msr_irq_en_i = 1'b1;
        #1;
        check("R10 irq raised", {7'h0, modem_irq_o}, 8'h01);
        read_msr();
        check("R10 irq drops after read", {7'h0, modem_irq_o}, 8'h00);
        msr_irq_en_i = 1'b0;
    endtask

    task automatic t_loop();
        pin_cts_i = 1'b1;
        mcr_i = 5'h10;
        step(1);
        core_txd_i = 1'b0; pin_rxd_i = 1'b1;
        #1;
        check("R3 tx idle", {7'h0, pin_txd_o}, 8'h01);
        check("R3 rx looped", {7'h0, core_rxd_o}, 8'h00);
        core_txd_i = 1'b1; pin_rxd_i = 1'b0;
        #1;
        check("R3 rx ignores pin", {7'h0, core_rxd_o}, 8'h01);
        mcr_i = 5'h1F;
        #1;
        check("R4 ctrl pins quiet", ctrl_pins(), 8'h00);
        mcr_i = 5'h10;
        step(3);
        check("R5 ext cts ignored", msr_o, 8'h00);
        mcr_i = 5'h12;
        step(1);
        check("R5 rts to cts", msr_o, 8'h11);
        read_msr();
        mcr_i = 5'h11;
        step(1);
        check("R5 dtr to dsr", msr_o, 8'h23);
        read_msr();
        mcr_i = 5'h14;
        step(1);
        check("R5 op1 to ri", msr_o, 8'h42);
        read_msr();
        mcr_i = 5'h18;
        step(1);
        check("R5 op2 to cd", msr_o, 8'h8C);
        read_msr();
        mcr_i = 5'h08;
        step(1);
        check("R1 exit at edge", ctrl_pins(), 8'h08);
        step(1);
        check("R11 exit source swap", msr_o, 8'h19);
        read_msr();
    endtask

    task automatic t_collide();
        pin_cts_i = 1'b0;
        step(2);
        msr_rd_i = 1'b1;
        step(1);
        msr_rd_i = 1'b0;
        check("R9 change beats clear", msr_o, 8'h01);
        read_msr();
        check("R9 cleared", msr_o, 8'h00);
    endtask

    initial begin
        t_reset();
        t_normal_path();
        t_normal_status();
        t_loop();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule